// File: doc/BRIEF.md
# Shared-Bus SPI Master with Per-Target Clock Modes

This block drives one SPI bus (SCLK, MOSI, MISO) that is shared by several targets, each reached through its own active-low select line. Every target owns a stored clock polarity, clock phase and clock divider. A host request names a target and a byte. The block looks up that target's settings, parks SCLK at the target's idle level, asserts the select, and shifts the byte out most significant bit first while it shifts a reply byte in.

Each received byte is returned with a one-cycle strobe. A one-cycle completion pulse follows once the select has been released. Clearing the last-byte flag of a request turns it into a burst: the select stays low, SCLK rests at its idle level, and the block waits for the next byte.

A configuration port writes a target's polarity, phase and divider. Settings change only while every select line is high. A write that arrives during a transfer is parked in a single pending slot, and a busy flag is raised until that write lands. In this way no selected target ever sees a clock edge produced under another target's settings.

Top module: `spi_multi_master`

## Requirements
- R1: Before a select line falls, SCLK has been at the addressed target's idle level (0 when its polarity bit is 0, 1 when it is 1) for at least one half-period, and SCLK is still at that level when the select falls.
- R2: With phase bit 0, the first MOSI bit is valid when the select falls. The master and the target sample on the first edge of each SCLK pulse, and each later bit changes on the second edge of the pulse before it.
- R3: With phase bit 1, each bit is driven on the first edge of its SCLK pulse and sampled on the second edge.
- R4: Bytes travel most significant bit first in both directions. Each completed byte is presented on rx_data with a one-cycle rx_valid strobe.
- R5: An SCLK half-period lasts (div+1) system clocks, where div is the addressed target's 8-bit divider. The first edge comes one half-period after the select falls.
- R6: The select bus is one-hot active-low. Only the addressed target's line (bit index equal to the target number) goes low, and never more than one line is low at once.
- R7: A request with req_last = 0 keeps the select low after its byte. While the block waits for the next byte, SCLK holds still, and req_tgt of the following request is ignored. A transfer of n bytes produces exactly 16·n SCLK edges.
- R8: After a select rises, at least (div+1) clocks of the next addressed target pass before any select falls again.
- R9: A configuration write made while any select is low is held pending, with cfg_busy = 1. The transfer in progress keeps its old settings, and the write is applied at the first cycle in which all selects are high, after which cfg_busy returns to 0. A write made while all selects are high takes effect at once.
- R10: A request is taken only while req_ready is 1, which happens when the block is idle or waiting inside a burst. req_valid at other times has no effect on the data exchanged.
- R11: done is a single-cycle pulse that rises in the cycle after the select line has risen.
- R12: After reset, all selects are high, SCLK is 0, done and cfg_busy are 0, and req_ready is 1. Every target starts with polarity 0, phase 0 and divider 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tgt | input | 2 | Target whose settings are written |
| cfg_cpol | input | 1 | Clock polarity for that target |
| cfg_cpha | input | 1 | Clock phase for that target |
| cfg_div | input | 8 | Half-period divider for that target |
| cfg_busy | output | 1 | A configuration write is pending |
| req_valid | input | 1 | Request strobe |
| req_tgt | input | 2 | Target of a new transfer (ignored inside a burst) |
| req_data | input | 8 | Byte to transmit |
| req_last | input | 1 | 1: release the select after this byte |
| req_ready | output | 1 | A request may be taken this cycle |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| done | output | 1 | Transfer finished pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the targets |
| miso | input | 1 | Serial data from the selected target |
| cs_n | output | 4 | Active-low per-target selects |

## Verification
The embedded assertions assume that the host changes a request only while req_ready is high or while req_valid is low. They also assume that MISO moves only on the target's own drive edges and is therefore stable at every sampling edge. The bench keeps to both. Its target model sits on the SCLK wire and updates MISO only on the edge opposite to its sampling edge. Requests are presented at falling system-clock edges and are held for exactly one accepted cycle. Random traffic mixes modes, dividers and burst lengths across targets. Directed cases add a configuration write during a burst, a request pushed while the block is shifting, and a mismatching target number inside a burst.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

   typedef struct packed {
      logic cpol;
      logic cpha;
   } spi_phase_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_HOLD,
      ST_FIN
   } spi_state_e;

endpackage

// File: rtl/spi_mm_cfg_bank.sv
module spi_mm_cfg_bank
   import spi_mm_pkg::*;
#(
   parameter int N_TGT   = 4,
   parameter int DIV_W   = 8,
   parameter int RST_DIV = 3,
   localparam int TGT_W  = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [TGT_W-1:0] wr_tgt,
   input  spi_phase_t       wr_mode,
   input  logic [DIV_W-1:0] wr_div,
   input  logic             bus_quiet,
   input  logic [TGT_W-1:0] rd_tgt,
   output spi_phase_t       rd_mode,
   output logic [DIV_W-1:0] rd_div,
   output logic             pend_o
);

   logic             pend_q;
   logic [TGT_W-1:0] pend_tgt_q;
   spi_phase_t       pend_mode_q;
   logic [DIV_W-1:0] pend_div_q;

   logic             direct_wr;
   logic             flush_pend;

   spi_phase_t       mode_v [N_TGT];
   logic [DIV_W-1:0] div_v  [N_TGT];

   assign direct_wr  = we && bus_quiet;
   assign flush_pend = pend_q && bus_quiet;

   generate
      for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
         spi_phase_t       mode_r;
         logic [DIV_W-1:0] div_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mode_r <= '0;
               div_r  <= DIV_W'(RST_DIV);
            end else if (direct_wr && wr_tgt == TGT_W'(i)) begin
               mode_r <= wr_mode;
               div_r  <= wr_div;
            end else if (flush_pend && pend_tgt_q == TGT_W'(i)) begin
               mode_r <= pend_mode_q;
               div_r  <= pend_div_q;
            end
         end
         assign mode_v[i] = mode_r;
         assign div_v[i]  = div_r;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_tgt_q  <= '0;
         pend_mode_q <= '0;
         pend_div_q  <= '0;
      end else if (we && !bus_quiet) begin
         pend_q      <= 1'b1;
         pend_tgt_q  <= wr_tgt;
         pend_mode_q <= wr_mode;
         pend_div_q  <= wr_div;
      end else if (flush_pend) begin
         pend_q <= 1'b0;
      end
   end

   always_comb begin
      rd_mode = '0;
      rd_div  = '0;
      for (int i = 0; i < N_TGT; i++) begin
         if (rd_tgt == TGT_W'(i)) begin
            rd_mode = mode_v[i];
            rd_div  = div_v[i];
         end
      end
   end

   assign pend_o = pend_q;

   // R9: a parked write survives while any select is low
   assert_pend_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !bus_quiet) |=> pend_q);

   // R9: a parked write lands once the bus is quiet
   assert_pend_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && bus_quiet) |=> !pend_q);

endmodule

// File: rtl/spi_mm_halfper.sv
module spi_mm_halfper #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (restart || cnt_q == '0)     cnt_q <= div;
      else                                 cnt_q <= cnt_q - 1'b1;
   end

   assign tick = (cnt_q == '0) && !restart;

   // R5: a nonzero divider never yields back-to-back ticks
   assert_half_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> !tick);

endmodule

// File: rtl/spi_mm_engine.sv
module spi_mm_engine
   import spi_mm_pkg::*;
#(
   parameter int N_TGT  = 4,
   parameter int DIV_W  = 8,
   parameter int DATA_W = 8,
   localparam int TGT_W = (N_TGT > 1) ? $clog2(N_TGT) : 1,
   localparam int EDGES = 2 * DATA_W,
   localparam int EC_W  = $clog2(EDGES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [TGT_W-1:0]  req_tgt,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_last,
   output logic              req_ready,
   input  spi_phase_t        sel_mode,
   input  logic [DIV_W-1:0]  sel_div,
   input  logic              tick,
   output logic              restart,
   output logic [DIV_W-1:0]  cur_div,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [N_TGT-1:0]  cs_n,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              done
);

   spi_state_e        state_q;
   logic [TGT_W-1:0]  tgt_q;
   spi_phase_t        mode_q;
   logic [DIV_W-1:0]  div_q;
   logic              last_q;
   logic [DATA_W-1:0] txsh_q;
   logic [DATA_W-1:0] rxsh_q;
   logic [EC_W-1:0]   ecnt_q;
   logic              sclk_q;
   logic              mosi_q;
   logic [N_TGT-1:0]  cs_q;
   logic              rxv_q;
   logic [DATA_W-1:0] rxd_q;
   logic              done_q;

   logic accept;
   logic ld_cpha;
   logic smp;
   logic last_trail;

   assign req_ready  = (state_q == ST_IDLE) || (state_q == ST_HOLD);
   assign accept     = req_valid && req_ready;
   assign restart    = accept;
   assign cur_div    = (state_q == ST_IDLE) ? sel_div : div_q;
   assign ld_cpha    = (state_q == ST_IDLE) ? sel_mode.cpha : mode_q.cpha;
   assign smp        = ~(ecnt_q[0] ^ mode_q.cpha);
   assign last_trail = (ecnt_q == EC_W'(EDGES - 1)) && !mode_q.cpha;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tgt_q   <= '0;
         mode_q  <= '0;
         div_q   <= '0;
         last_q  <= 1'b0;
         txsh_q  <= '0;
         rxsh_q  <= '0;
         ecnt_q  <= '0;
         sclk_q  <= 1'b0;
         mosi_q  <= 1'b0;
         cs_q    <= '1;
         rxv_q   <= 1'b0;
         rxd_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         rxv_q  <= 1'b0;
         done_q <= 1'b0;
         if (accept) begin
            last_q <= req_last;
            ecnt_q <= '0;
            if (!ld_cpha) begin
               mosi_q <= req_data[DATA_W-1];
               txsh_q <= req_data << 1;
            end else begin
               txsh_q <= req_data;
            end
         end
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  tgt_q   <= req_tgt;
                  mode_q  <= sel_mode;
                  div_q   <= sel_div;
                  sclk_q  <= sel_mode.cpol;
                  state_q <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  cs_q    <= ~(N_TGT'(1) << tgt_q);
                  state_q <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (ecnt_q == EC_W'(EDGES)) begin
                     rxv_q <= 1'b1;
                     rxd_q <= rxsh_q;
                     if (last_q) begin
                        cs_q    <= '1;
                        state_q <= ST_FIN;
                     end else begin
                        state_q <= ST_HOLD;
                     end
                  end else begin
                     sclk_q <= ~sclk_q;
                     ecnt_q <= ecnt_q + 1'b1;
                     if (smp) begin
                        rxsh_q <= {rxsh_q[DATA_W-2:0], miso};
                     end else if (!last_trail) begin
                        mosi_q <= txsh_q[DATA_W-1];
                        txsh_q <= txsh_q << 1;
                     end
                  end
               end
            end
            ST_HOLD: begin
               if (accept) state_q <= ST_SHIFT;
            end
            ST_FIN: begin
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sclk     = sclk_q;
   assign mosi     = mosi_q;
   assign cs_n     = cs_q;
   assign rx_valid = rxv_q;
   assign rx_data  = rxd_q;
   assign done     = done_q;

   // R6: never more than one select low
   assert_cs_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_q));

   // R1: select falls with SCLK parked at the latched idle level
   assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(&cs_q) |-> (sclk_q == mode_q.cpol));

   // R7: no SCLK movement while waiting inside a burst, select stays low
   assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> ($stable(sclk_q) && !(&cs_q)));

   // R10: target cannot change while shifting
   assert_tgt_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SHIFT && $past(state_q) == ST_SHIFT) |-> $stable(tgt_q));

   // R11: done follows the select release by one cycle
   assert_done_after_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ((&cs_q) && $past(&cs_q) && !$past(&cs_q, 2)));

endmodule

// File: rtl/spi_multi_master.sv
module spi_multi_master
   import spi_mm_pkg::*;
#(
   parameter int N_TGT   = 4,
   parameter int DIV_W   = 8,
   parameter int DATA_W  = 8,
   parameter int RST_DIV = 3,
   localparam int TGT_W  = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [TGT_W-1:0]  cfg_tgt,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [DIV_W-1:0]  cfg_div,
   output logic              cfg_busy,
   input  logic              req_valid,
   input  logic [TGT_W-1:0]  req_tgt,
   input  logic [DATA_W-1:0] req_data,
   input  logic              req_last,
   output logic              req_ready,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              done,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [N_TGT-1:0]  cs_n
);

   generate
      if (N_TGT < 2) begin : g_bad_tgt
         $error("spi_multi_master: N_TGT must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("spi_multi_master: DATA_W must be at least 2");
      end
      if (DIV_W < 1 || RST_DIV >= (1 << DIV_W)) begin : g_bad_div
         $error("spi_multi_master: RST_DIV does not fit DIV_W");
      end
   endgenerate

   spi_phase_t       wr_mode;
   spi_phase_t       sel_mode;
   logic [DIV_W-1:0] sel_div;
   logic [DIV_W-1:0] cur_div;
   logic             restart;
   logic             tick;
   logic             bus_quiet;

   assign wr_mode   = '{cpol: cfg_cpol, cpha: cfg_cpha};
   assign bus_quiet = &cs_n;

   spi_mm_cfg_bank #(
      .N_TGT   (N_TGT),
      .DIV_W   (DIV_W),
      .RST_DIV (RST_DIV)
   ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .wr_tgt    (cfg_tgt),
      .wr_mode   (wr_mode),
      .wr_div    (cfg_div),
      .bus_quiet (bus_quiet),
      .rd_tgt    (req_tgt),
      .rd_mode   (sel_mode),
      .rd_div    (sel_div),
      .pend_o    (cfg_busy)
   );

   spi_mm_halfper #(
      .DIV_W (DIV_W)
   ) half_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .div     (cur_div),
      .tick    (tick)
   );

   spi_mm_engine #(
      .N_TGT  (N_TGT),
      .DIV_W  (DIV_W),
      .DATA_W (DATA_W)
   ) eng_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_tgt   (req_tgt),
      .req_data  (req_data),
      .req_last  (req_last),
      .req_ready (req_ready),
      .sel_mode  (sel_mode),
      .sel_div   (sel_div),
      .tick      (tick),
      .restart   (restart),
      .cur_div   (cur_div),
      .sclk      (sclk),
      .mosi      (mosi),
      .miso      (miso),
      .cs_n      (cs_n),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .done      (done)
   );

endmodule

// File: tb/spi_multi_master_tb.sv
`timescale 1ns/1ps
module spi_multi_master_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_tgt = '0;
   logic       cfg_cpol = 1'b0;
   logic       cfg_cpha = 1'b0;
   logic [7:0] cfg_div = '0;
   logic       cfg_busy;
   logic       req_valid = 1'b0;
   logic [1:0] req_tgt = '0;
   logic [7:0] req_data = '0;
   logic       req_last = 1'b0;
   logic       req_ready;
   logic       rx_valid;
   logic [7:0] rx_data;
   logic       done;
   logic       sclk;
   logic       mosi;
   logic       miso;
   logic [3:0] cs_n;

   always #2 clk = ~clk;

   spi_multi_master dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tgt(cfg_tgt),
      .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_div(cfg_div),
      .cfg_busy(cfg_busy), .req_valid(req_valid), .req_tgt(req_tgt),
      .req_data(req_data), .req_last(req_last), .req_ready(req_ready),
      .rx_valid(rx_valid), .rx_data(rx_data), .done(done), .sclk(sclk),
      .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // shadow of the per-target settings
   bit   sh_cpol [4];
   bit   sh_cpha [4];
   int   sh_div  [4];

   // current transfer context
   int       tb_tgt, tb_div;
   bit       tb_cpol, tb_cpha;
   logic [7:0] tb_first;
   logic [7:0] salt;
   logic [7:0] tx_bytes [8];
   logic [7:0] slv_rx   [8];
   logic [7:0] dut_rx   [8];
   int       nrx_dut;

   function automatic logic [7:0] slv_byte(input int k);
      return 8'hA5 ^ 8'(k * 29) ^ salt;
   endfunction

   function automatic logic slv_bit(input int s);
      logic [7:0] b;
      b = slv_byte(s / 8);
      return b[7 - (s % 8)];
   endfunction

   // target model sitting on the wires
   logic       cs_all;
   logic       miso_r = 1'b0;
   logic [7:0] slv_sh = '0;
   int         s_cnt = 0;
   assign cs_all = &cs_n;
   assign miso   = miso_r;

   always @(negedge cs_all) begin
      s_cnt = 0;
      if (!tb_cpha) miso_r = slv_bit(0);
   end

   always @(sclk) begin
      if (!cs_all) begin
         bit lead;
         lead = (sclk != tb_cpol);
         if (lead ^ tb_cpha) begin
            slv_sh = {slv_sh[6:0], mosi};
            s_cnt++;
            if (s_cnt % 8 == 0) slv_rx[s_cnt / 8 - 1] = slv_sh;
         end else begin
            miso_r = slv_bit(s_cnt);
         end
      end
   end

   // monitor, sampled away from the active edge
   int  cyc = 0;
   int  cs_fall_cyc = 0;
   int  cs_rise_cyc = -1000;
   int  last_e = 0;
   int  e_cnt = 0;
   bit  hp_bad = 0;
   bit  oh_bad = 0;
   logic sclk_prev = 1'b0;
   logic csd1 = 1'b1;
   logic csd2 = 1'b1;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (csd1 && !cs_all) begin
            cs_fall_cyc = cyc;
            chk(cyc - cs_rise_cyc >= tb_div + 1, "R8 gap", cyc - cs_rise_cyc, tb_div + 1);
            chk(sclk == tb_cpol, "R1 idle level", int'(sclk), int'(tb_cpol));
            chk(~cs_n == 4'(1 << tb_tgt), "R6 select", int'(~cs_n), 1 << tb_tgt);
            if (!tb_cpha) chk(mosi == tb_first[7], "R2 first bit", int'(mosi), int'(tb_first[7]));
         end
         if (!csd1 && cs_all) cs_rise_cyc = cyc;
         if (!cs_all && ~cs_n != 4'(1 << tb_tgt)) oh_bad = 1;
         if (sclk !== sclk_prev && !cs_all) begin
            if (e_cnt == 0) begin
               if (cyc - cs_fall_cyc != tb_div + 1) hp_bad = 1;
            end else if (e_cnt % 16 != 0) begin
               if (cyc - last_e != tb_div + 1) hp_bad = 1;
            end
            last_e = cyc;
            e_cnt++;
         end
         if (rx_valid) begin
            if (nrx_dut < 8) dut_rx[nrx_dut] = rx_data;
            nrx_dut++;
         end
         if (done) chk(csd1 && !csd2, "R11 done timing", int'({csd2, csd1}), 1);
      end
      sclk_prev = sclk;
      csd2 = csd1;
      csd1 = cs_all;
   end

   task automatic cfg_write(input int t, input bit pol, input bit pha, input int dv, input bit upd);
      @(negedge clk);
      cfg_we = 1'b1; cfg_tgt = 2'(t); cfg_cpol = pol; cfg_cpha = pha; cfg_div = 8'(dv);
      @(negedge clk);
      cfg_we = 1'b0;
      if (upd) begin
         sh_cpol[t] = pol; sh_cpha[t] = pha; sh_div[t] = dv;
      end
   endtask

   // n bytes to target t; intr pushes a stray request while busy (R10)
   task automatic xfer(input int t, input int n, input bit intr);
      tb_tgt = t; tb_cpol = sh_cpol[t]; tb_cpha = sh_cpha[t]; tb_div = sh_div[t];
      tb_first = tx_bytes[0];
      salt = 8'($urandom);
      nrx_dut = 0; e_cnt = 0; hp_bad = 0; oh_bad = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         while (!req_ready) @(negedge clk);
         req_valid = 1'b1;
         req_tgt   = (i == 0) ? 2'(t) : 2'(t + 1);
         req_data  = tx_bytes[i];
         req_last  = (i == n - 1);
         @(negedge clk);
         req_valid = 1'b0;
         if (intr && i == 0) begin
            repeat (2) @(negedge clk);
            chk(req_ready == 1'b0, "R10 not ready while busy", int'(req_ready), 0);
            req_valid = 1'b1; req_data = ~tx_bytes[0]; req_tgt = 2'(t + 2); req_last = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
         end
      end
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(nrx_dut == n, "R4 byte count", nrx_dut, n);
      for (int k = 0; k < n; k++) begin
         chk(dut_rx[k] == slv_byte(k), "R4 received byte", int'(dut_rx[k]), int'(slv_byte(k)));
         chk(slv_rx[k] == tx_bytes[k], tb_cpha ? "R3 sent byte" : "R2 sent byte",
             int'(slv_rx[k]), int'(tx_bytes[k]));
      end
      chk(e_cnt == 16 * n, "R7 edge count", e_cnt, 16 * n);
      chk(!hp_bad, "R5 half period", int'(hp_bad), 0);
      chk(!oh_bad, "R6 one-hot select", int'(oh_bad), 0);
      if (intr) chk(slv_rx[0] == tx_bytes[0], "R10 stray request ignored", int'(slv_rx[0]), int'(tx_bytes[0]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 4; i++) begin
         sh_cpol[i] = 0; sh_cpha[i] = 0; sh_div[i] = 3;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      chk(cs_n == 4'hF, "R12 selects high", int'(cs_n), 15);
      chk(sclk == 1'b0, "R12 sclk low", int'(sclk), 0);
      chk(done == 1'b0, "R12 done low", int'(done), 0);
      chk(cfg_busy == 1'b0, "R12 busy low", int'(cfg_busy), 0);
      chk(req_ready == 1'b1, "R12 ready", int'(req_ready), 1);

      // reset settings used directly (R12)
      tx_bytes[0] = 8'h3C;
      xfer(0, 1, 0);

      // one target per mode (R1, R2, R3, R5)
      cfg_write(0, 0, 0, 1, 1);
      cfg_write(1, 1, 0, 2, 1);
      cfg_write(2, 0, 1, 0, 1);
      cfg_write(3, 1, 1, 4, 1);
      for (int t = 0; t < 4; t++) begin
         tx_bytes[0] = 8'(8'h81 + t * 8'h16);
         xfer(t, 1, 0);
      end

      // burst with mismatching target on later bytes (R7)
      tx_bytes[0] = 8'hF0; tx_bytes[1] = 8'h0F; tx_bytes[2] = 8'h99;
      xfer(3, 3, 0);

      // back-to-back different polarity targets (R1, R8)
      tx_bytes[0] = 8'h00;
      xfer(1, 1, 0);
      tx_bytes[0] = 8'hFF;
      xfer(2, 1, 0);

      // stray request while busy (R10)
      tx_bytes[0] = 8'h5A;
      xfer(3, 1, 1);

      // write during a burst is parked (R9)
      tx_bytes[0] = 8'h12; tx_bytes[1] = 8'h34;
      fork
         xfer(1, 2, 0);
         begin
            @(negedge clk);
            while (cs_all) @(negedge clk);
            repeat (3) @(negedge clk);
            cfg_write(1, 0, 1, 5, 0);
            chk(cfg_busy == 1'b1, "R9 busy while selected", int'(cfg_busy), 1);
         end
      join
      chk(cfg_busy == 1'b0, "R9 busy cleared", int'(cfg_busy), 0);
      sh_cpol[1] = 0; sh_cpha[1] = 1; sh_div[1] = 5;
      tx_bytes[0] = 8'hC3;
      xfer(1, 1, 0);

      // random traffic
      for (int r = 0; r < 30; r++) begin
         int t, n;
         if ($urandom % 3 == 0)
            cfg_write(int'($urandom % 4), bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 5), 1);
         t = int'($urandom % 4);
         n = 1 + int'($urandom % 3);
         for (int k = 0; k < n; k++) tx_bytes[k] = 8'($urandom);
         xfer(t, n, 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule